// File: doc/BRIEF.md
# Serial Controller Interrupt Identification

This block decides which interrupt a byte-wide serial controller reports, and when. The receive and transmit datapaths sit outside it. Five event conditions come in: a receiver line error pulse, the receive buffer fill level with its trigger threshold, a character-timeout level, the transmit-holding-empty level, and a modem status change pulse. Each passes through an enable register. A small state machine keeps the highest-priority enabled source and presents it as a fixed identification code. A processor reads that code over a simple address/strobe register port. The request pin is asserted only while a pending source exists and bit 3 of the modem-control register is set.

The state machine has six states: `SRC_NONE`, `SRC_LINE`, `SRC_RXDATA`, `SRC_TIMEOUT`, `SRC_TXEMPTY` and `SRC_MODEM`. On every clock it moves from whichever state it holds to the state of the highest-priority enabled request, and to `SRC_NONE` when no request is active. Line error and modem change events are latched until their status registers are read. Transmit-empty is latched on a rising edge and cleared by the accesses that acknowledge it. The receive-data and timeout sources follow their input levels.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification register (address 2) reads 0x01, the enable register (address 1) reads 0x00 and `irq` is low.
- R2: The enable register at address 1 holds 4 bits and reads back as {4'b0, bits}. Bit 0 enables received data and timeout, bit 1 enables transmit empty, bit 2 enables line status and bit 3 enables modem status. A disabled source is never reported.
- R3: Identification bits 3:0 read 0x6 for line status, 0x4 for received data, 0xC for character timeout, 0x2 for transmit empty, 0x0 for modem status, and 0x1 when nothing is pending. Bits 5:4 read 0.
- R4: When several enabled sources are active, the one reported follows this priority: line status, then received data, then timeout, then transmit empty, then modem status.
- R5: Identification bits 7:6 read 2'b11 while `fifo_en` is high and 2'b00 otherwise.
- R6: The modem-control register at address 4 holds 8 bits and reads back in full. `irq` is high exactly when bit 3 of that register is set and a source is being reported.
- R7: A pending transmit-empty source is cleared by a write to address 0, or by a read of address 2 while transmit empty is the reported source.
- R8: A line-error event stays pending until address 5 is read. A modem change stays pending until address 6 is read. If an event arrives in the same cycle as its clearing read, the event wins.
- R9: The received-data source is active exactly while `rx_level` >= `rx_trig`.
- R10: Transmit empty becomes pending on a rising edge of `tx_empty`, or when enable bit 1 rises while `tx_empty` is high.
- R11: A read of address 2 while another source is being reported leaves a pending transmit-empty source intact.
- R12: The reported state updates one clock after a source's condition changes. Latched events therefore show two clocks after their input pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register address |
| rd_en | input | 1 | Read strobe (one cycle per access) |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| line_err | input | 1 | Receiver line error event pulse |
| rx_level | input | LVL_W | Receive buffer fill level |
| rx_trig | input | LVL_W | Receive trigger threshold |
| rx_timeout | input | 1 | Character timeout condition (level) |
| tx_empty | input | 1 | Transmit holding empty (level) |
| modem_chg | input | 1 | Modem status change event pulse |
| fifo_en | input | 1 | Buffers enabled status |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can land in one cycle: an event sets a sticky source while the read that acknowledges that same source clears it. The bench provokes this for the line source by pulsing `line_err` in the exact cycle that carries the address-5 read strobe. It then requires the identification register to still show the line-status code, because the event must win. A second overlap is a read of address 2 while a higher source hides a pending transmit-empty. That read must not clear it, and the bench checks that once the line source is gone, transmit-empty is the next code reported.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_LINE,
        SRC_RXDATA,
        SRC_TIMEOUT,
        SRC_TXEMPTY,
        SRC_MODEM
    } src_e;

    localparam logic [2:0] A_TXDATA    = 3'd0;
    localparam logic [2:0] A_ENABLE    = 3'd1;
    localparam logic [2:0] A_IDENT     = 3'd2;
    localparam logic [2:0] A_MODEMCTL  = 3'd4;
    localparam logic [2:0] A_LINESTAT  = 3'd5;
    localparam logic [2:0] A_MODEMSTAT = 3'd6;

    function automatic logic [3:0] ident_code(src_e s);
        logic [3:0] c;
        unique case (s)
            SRC_LINE:    c = 4'h6;
            SRC_RXDATA:  c = 4'h4;
            SRC_TIMEOUT: c = 4'hC;
            SRC_TXEMPTY: c = 4'h2;
            SRC_MODEM:   c = 4'h0;
            default:     c = 4'h1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/uart_irq_sources.sv
module uart_irq_sources (
    input  logic clk,
    input  logic rst_n,
    input  logic line_evt,
    input  logic modem_evt,
    input  logic tx_empty,
    input  logic thre_en,
    input  logic clr_line,
    input  logic clr_modem,
    input  logic clr_thre,
    output logic line_pend,
    output logic modem_pend,
    output logic thre_pend
);
    logic tx_empty_q;
    logic thre_en_q;
    logic thre_set;

    // Rising edge of the empty level, or the enable rising while empty
    assign thre_set = (tx_empty && !tx_empty_q) || (tx_empty && thre_en && !thre_en_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_pend  <= 1'b0;
            modem_pend <= 1'b0;
            thre_pend  <= 1'b0;
            tx_empty_q <= 1'b0;
            thre_en_q  <= 1'b0;
        end else begin
            tx_empty_q <= tx_empty;
            thre_en_q  <= thre_en;
            // A new event beats a clearing access in the same cycle
            if (line_evt)       line_pend <= 1'b1;
            else if (clr_line)  line_pend <= 1'b0;
            if (modem_evt)      modem_pend <= 1'b1;
            else if (clr_modem) modem_pend <= 1'b0;
            if (thre_set)       thre_pend <= 1'b1;
            else if (clr_thre)  thre_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_req,
    input  logic       rx_req,
    input  logic       cto_req,
    input  logic       tx_req,
    input  logic       ms_req,
    output src_e       state,
    output logic [3:0] code
);
    src_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SRC_NONE;
        else        state <= state_d;
    end

    // Transition: from any state to the highest-priority active request
    always_comb begin
        priority casez ({line_req, rx_req, cto_req, tx_req, ms_req})
            5'b1????: state_d = SRC_LINE;
            5'b01???: state_d = SRC_RXDATA;
            5'b001??: state_d = SRC_TIMEOUT;
            5'b0001?: state_d = SRC_TXEMPTY;
            5'b00001: state_d = SRC_MODEM;
            default:  state_d = SRC_NONE;
        endcase
    end

    always_comb begin
        code = ident_code(state);
    end
endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] addr,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    input  logic [7:0] ident_byte,
    output logic [3:0] ier,
    output logic [7:0] mcr,
    output logic [7:0] rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ier <= '0;
            mcr <= '0;
        end else if (wr_en) begin
            if (addr == A_ENABLE)   ier <= wdata[3:0];
            if (addr == A_MODEMCTL) mcr <= wdata;
        end
    end

    always_comb begin
        unique case (addr)
            A_ENABLE:   rdata = {4'h0, ier};
            A_IDENT:    rdata = ident_byte;
            A_MODEMCTL: rdata = mcr;
            default:    rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       addr,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    input  logic             line_err,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_trig,
    input  logic             rx_timeout,
    input  logic             tx_empty,
    input  logic             modem_chg,
    input  logic             fifo_en,
    output logic             irq
);
    localparam int GATE_BIT = 3;

    logic [3:0] ier;
    logic [7:0] mcr;
    logic       line_pend, modem_pend, thre_pend;
    src_e       state;
    logic [3:0] code;
    logic [7:0] ident_byte;
    logic       ident_rd;

    assign ident_rd   = rd_en && (addr == A_IDENT);
    assign ident_byte = {fifo_en ? 2'b11 : 2'b00, 2'b00, code};

    uart_irq_sources u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_evt  (line_err),
        .modem_evt (modem_chg),
        .tx_empty  (tx_empty),
        .thre_en   (ier[1]),
        .clr_line  (rd_en && (addr == A_LINESTAT)),
        .clr_modem (rd_en && (addr == A_MODEMSTAT)),
        .clr_thre  ((wr_en && (addr == A_TXDATA)) || (ident_rd && (state == SRC_TXEMPTY))),
        .line_pend (line_pend),
        .modem_pend(modem_pend),
        .thre_pend (thre_pend)
    );

    uart_irq_arbiter u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_req(ier[2] && line_pend),
        .rx_req  (ier[0] && (rx_level >= rx_trig)),
        .cto_req (ier[0] && rx_timeout),
        .tx_req  (ier[1] && thre_pend),
        .ms_req  (ier[3] && modem_pend),
        .state   (state),
        .code    (code)
    );

    uart_irq_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .wr_en     (wr_en),
        .wdata     (wdata),
        .ident_byte(ident_byte),
        .ier       (ier),
        .mcr       (mcr),
        .rdata     (rdata)
    );

    assign irq = mcr[GATE_BIT] && (state != SRC_NONE);
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk
    import uart_irq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] addr,
    input logic       rd_en,
    input logic       wr_en,
    input logic       line_err,
    input logic       modem_chg,
    input logic       tx_empty,
    input logic [3:0] ier,
    input logic       line_pend,
    input logic       modem_pend,
    input logic       thre_pend,
    input src_e       state
);
    // R4: an enabled line error always wins the next report
    p_line_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ier[2] && line_pend) |=> (state == SRC_LINE));

    // R8: status read without a fresh event clears the line source
    p_line_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_LINESTAT && !line_err) |=> !line_pend);

    // R8: modem status read without a fresh change clears the modem source
    p_modem_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_MODEMSTAT && !modem_chg) |=> !modem_pend);

    // R7: a transmit write with the holding register busy leaves nothing pending
    p_thre_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_TXDATA && !tx_empty) |=> !thre_pend);

    // R8: an event in the cycle of its clearing read survives
    p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (line_err && rd_en && addr == A_LINESTAT) |=> line_pend);
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .line_err  (line_err),
    .modem_chg (modem_chg),
    .tx_empty  (tx_empty),
    .ier       (ier),
    .line_pend (line_pend),
    .modem_pend(modem_pend),
    .thre_pend (thre_pend),
    .state     (state)
);

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;
    localparam int LVL_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       addr = '0;
    logic             rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0]       wdata = '0;
    logic [7:0]       rdata;
    logic             line_err = 1'b0, rx_timeout = 1'b0, tx_empty = 1'b0;
    logic             modem_chg = 1'b0, fifo_en = 1'b0;
    logic [LVL_W-1:0] rx_level = '0, rx_trig = 5'd1;
    logic             irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    uart_irq_ident #(.LVL_W(LVL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .line_err(line_err), .rx_level(rx_level),
        .rx_trig(rx_trig), .rx_timeout(rx_timeout), .tx_empty(tx_empty),
        .modem_chg(modem_chg), .fifo_en(fifo_en), .irq(irq)
    );

    function automatic logic [7:0] exp_ident(logic [3:0] ier, logic ls, logic rxok,
                                             logic cto, logic thre, logic ms, logic fe);
        logic [3:0] c;
        if (ier[2] && ls)        c = 4'h6;
        else if (ier[0] && rxok) c = 4'h4;
        else if (ier[0] && cto)  c = 4'hC;
        else if (ier[1] && thre) c = 4'h2;
        else if (ier[3] && ms)   c = 4'h0;
        else                     c = 4'h1;
        return {fe ? 2'b11 : 2'b00, 2'b00, c};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        tick();
        tick();
    endtask

    task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic peek(logic [2:0] a, output logic [7:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic check_ident(string req, logic [7:0] exp);
        logic [7:0] d;
        peek(3'd2, d);
        check8(req, d, exp);
    endtask

    task automatic bus_write(logic [2:0] a, logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic bus_read(logic [2:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #0.5;
        d = rdata;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic pulse_line();
        line_err = 1'b1; tick(); line_err = 1'b0;
    endtask

    task automatic pulse_modem();
        modem_chg = 1'b1; tick(); modem_chg = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: got %0d cycles expected completion", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd4711));
        tick(); tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        check_ident("R1 ident", 8'h01);
        peek(3'd1, d); check8("R1 enable", d, 8'h00);
        check8("R1 irq", {7'd0, irq}, 8'h00);

        // R2: enable readback
        bus_write(3'd1, 8'hFF);
        peek(3'd1, d); check8("R2 enable readback", d, 8'h0F);

        // R5: buffer status bits
        fifo_en = 1'b1; #0.5;
        check_ident("R5 fifo bits", 8'hC1);
        fifo_en = 1'b0;

        // R3, R6, R8: line source with gate
        pulse_line(); settle();
        check_ident("R3 line code", 8'h06);
        check8("R6 irq gated off", {7'd0, irq}, 8'h00);
        bus_write(3'd4, 8'h0B);
        peek(3'd4, d); check8("R6 modem ctl readback", d, 8'h0B);
        check8("R6 irq on", {7'd0, irq}, 8'h01);
        bus_read(3'd5, d); settle();
        check_ident("R8 line cleared", 8'h01);
        check8("R6 irq idle", {7'd0, irq}, 8'h00);

        // R9, R3: receive level against trigger
        rx_trig = 5'd4; rx_level = 5'd4; settle();
        check_ident("R9 level at trigger", 8'h04);
        rx_level = 5'd3; settle();
        check_ident("R9 level below trigger", 8'h01);

        // R3, R4: timeout vs received data
        rx_timeout = 1'b1; settle();
        check_ident("R3 timeout code", 8'h0C);
        rx_level = 5'd9; settle();
        check_ident("R4 rxdata over timeout", 8'h04);
        rx_timeout = 1'b0; rx_level = 5'd0; settle();

        // R3, R8: modem source
        pulse_modem(); settle();
        check_ident("R3 modem code", 8'h00);
        bus_read(3'd6, d); settle();
        check_ident("R8 modem cleared", 8'h01);

        // R10, R4, R11, R7: transmit empty
        tx_empty = 1'b1; settle();
        check_ident("R10 tx empty edge", 8'h02);
        pulse_line(); settle();
        check_ident("R4 line over txempty", 8'h06);
        bus_read(3'd2, d);
        bus_read(3'd5, d); settle();
        check_ident("R11 txempty survives ident read", 8'h02);
        bus_read(3'd2, d); settle();
        check_ident("R7 ident read clears txempty", 8'h01);
        tx_empty = 1'b0; tick(); tx_empty = 1'b1; settle();
        check_ident("R10 second edge", 8'h02);
        bus_write(3'd0, 8'h55); settle();
        check_ident("R7 tx write clears", 8'h01);

        // R10: enable rising while empty
        bus_write(3'd1, 8'h0D); settle();
        bus_write(3'd1, 8'h0F); settle();
        check_ident("R10 enable rise", 8'h02);
        bus_write(3'd0, 8'h00); settle();
        tx_empty = 1'b0; settle();

        // R8: event and clearing read in one cycle
        addr = 3'd5; rd_en = 1'b1; line_err = 1'b1;
        tick();
        rd_en = 1'b0; line_err = 1'b0; settle();
        check_ident("R8 event wins", 8'h06);

        // R2: masked source not reported
        bus_write(3'd1, 8'h0B); settle();
        check_ident("R2 line masked", 8'h01);
        check8("R2 irq masked", {7'd0, irq}, 8'h00);
        bus_read(3'd5, d);
        bus_write(3'd1, 8'h0F); settle();

        // Random mix, R12 timing: checked two clocks after stimulus
        for (int i = 0; i < 300; i++) begin
            logic [3:0] ier_r;
            logic       ls, ms, gate;
            logic [7:0] e;
            ier_r      = 4'($urandom);
            ls         = 1'($urandom);
            ms         = 1'($urandom);
            gate       = 1'($urandom);
            fifo_en    = 1'($urandom);
            rx_level   = 5'($urandom % 17);
            rx_trig    = 5'(1 + $urandom % 16);
            rx_timeout = 1'($urandom);
            bus_write(3'd1, {4'h0, ier_r});
            bus_write(3'd4, {4'h0, gate, 3'b000});
            line_err = ls; modem_chg = ms;
            tick();
            line_err = 1'b0; modem_chg = 1'b0;
            settle();
            e = exp_ident(ier_r, ls, rx_level >= rx_trig, rx_timeout, 1'b0, ms, fifo_en);
            check_ident("R12 random ident", e);
            check8("R6 random irq", {7'd0, irq}, {7'd0, gate && (e[3:0] != 4'h1)});
            bus_read(3'd5, d);
            bus_read(3'd6, d);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule